// File: doc/BRIEF.md
# Multichannel SAR ADC Serial Conversion Controller

This block is the host-side master for a 4- or 8-channel successive-approximation converter attached over SPI (mode 0). A host asks for a conversion by presenting a channel number with a request. The controller then runs a read-modify-write on its cached 14-bit configuration word, changing only the channel field, and sends that word to the converter in one frame. In the next frame it clocks in the result with MOSI held low. It returns the conversion code with a one-cycle valid strobe. The host can also overwrite the whole configuration word, and the cached copy is always visible on a read-back port.

The frame length is not fixed. It equals the converter resolution, plus 14 bits whenever the configuration's active-low read-back bit (bit 0) is clear. A configuration word is always sent at the most significant end of its frame. After every frame, chip select stays high for a gap of at least 2 µs, which is counted in clock cycles from a clock-frequency parameter. After reset the controller loads a default configuration into the converter and performs two throw-away conversions before it accepts any host request.

Top module: `adc_spi_ctrl`

## Requirements
- R1: After reset the cached configuration reads 0x3C79 and `busy_o` is high. The controller sends 0x3C79 in a RES-bit frame, then performs two channel-0 reads (a configuration frame followed by a receive frame, each), producing no `valid_o` pulse. Only then does `busy_o` fall.
- R2: A full configuration write stores `cfg_wdata_i[13:0]` and discards bits 15:14. It sends the new word shifted left by (frame length − 14). The frame length is chosen from the read-back bit as it stood before the write.
- R3: A channel read first sends a configuration frame. That frame is the cached word with bits 9:7 replaced by the channel number (zero-extended) and every other bit unchanged, and the cache keeps this new word.
- R4: The second frame of a read has the same length as the first, and MOSI stays 0 throughout it.
- R5: With configuration bit 0 = 1, every frame is RES bits long, and `data_o` equals the RES received bits.
- R6: With configuration bit 0 = 0, every frame is RES+14 bits long, and `data_o` equals received bits [RES+13:14] (the received word shifted right by 14).
- R7: Between the end of one frame and the start of the next, `cs_n_o` stays high for at least ceil(CLK_HZ·GAP_NS/1e9) clock cycles (100 at 50 MHz and 2000 ns).
- R8: Requests are levels sampled only while idle. `busy_o` is high from acceptance until the final gap has elapsed. `valid_o` is a single-cycle pulse, once per host read, raised while busy. A configuration write presented during a read is held until that read, including its gap, has finished.
- R9: The SPI link runs in mode 0. SCLK idles low while chip select is high, MOSI and MISO change after falling edges, and both are sampled on rising edges, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Conversion request (level, taken when idle) |
| req_ch_i | input | CHW | Channel for the conversion |
| cfg_wr_i | input | 1 | Full configuration write request (level, taken when idle, wins over req_i) |
| cfg_wdata_i | input | 16 | Configuration write data; bits 15:14 ignored |
| busy_o | output | 1 | Sequence in progress (including start-up and gaps) |
| valid_o | output | 1 | One-cycle strobe, data_o holds a new code |
| data_o | output | RES | Conversion code |
| cfg_rdata_o | output | 14 | Cached configuration word |
| sclk_o | output | 1 | SPI clock (idle low) |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to converter |
| miso_i | input | 1 | SPI data from converter |

## Verification
The embedded assertions check four things on every cycle. SCLK and MOSI must be quiet whenever chip select is high. No frame may start before the inter-frame gap has elapsed. `valid_o` must be a single-cycle pulse raised only while busy. Every accepted write or channel update must leave the cache holding exactly the masked or field-merged value. Only the bench's converter model can show the frame contents, which are the left alignment, the bit count chosen from the read-back bit before the write, and the all-zero receive frame. The same holds for the extraction of the code with read-back on and off, the five-frame start-up sequence, and a configuration write deferred behind a running read.

// File: rtl/adc_ctrl_pkg.sv
// Package: shared constants and state type for the ADC serial controller.
// Assumes a 14-bit converter configuration word with the channel field at 9:7.
package adc_ctrl_pkg;
    localparam int CFG_W  = 14;
    localparam int CH_LSB = 7;
    localparam int CH_FW  = 3;
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 14'h3C79;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_XFER,
        SQ_GAP
    } seq_state_t;
endpackage

// File: rtl/adc_cfg_cache.sv
// Module: cached copy of the converter configuration register.
// Does: full overwrite or channel-field-only update; full write has priority.
// Assumes: channel number fits the 3-bit field (CHW <= 3).
module adc_cfg_cache
    import adc_ctrl_pkg::*;
#(
    parameter int CHW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_wr_i,
    input  logic [CFG_W-1:0] full_data_i,
    input  logic             ch_wr_i,
    input  logic [CHW-1:0]   ch_i,
    output logic [CFG_W-1:0] cfg_o
);
    // Purpose: hold the configuration word, merging channel updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= CFG_DEFAULT;
        end else if (full_wr_i) begin
            cfg_o <= full_data_i;
        end else if (ch_wr_i) begin
            cfg_o[CH_LSB +: CH_FW] <= CH_FW'(ch_i);
        end
    end

    // R3: a channel update leaves all bits outside 9:7 untouched
    a_r3_field_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_wr_i && !full_wr_i) |=>
            (cfg_o[CFG_W-1:CH_LSB+CH_FW] == $past(cfg_o[CFG_W-1:CH_LSB+CH_FW])) &&
            (cfg_o[CH_LSB-1:0] == $past(cfg_o[CH_LSB-1:0])) &&
            (cfg_o[CH_LSB +: CH_FW] == CH_FW'($past(ch_i))));
endmodule

// File: rtl/adc_gap_timer.sv
// Module: inter-frame gap counter.
// Does: after a start pulse, raises done_o once GAP_CYC cycles have elapsed.
// Assumes: GAP_CYC >= 1.
module adc_gap_timer #(
    parameter int GAP_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = $clog2(GAP_CYC + 1);

    logic          run_q;
    logic [CW-1:0] cnt_q;

    // Purpose: count down the gap window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= CW'(GAP_CYC - 1);
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/adc_spi_frame.sv
// Module: one SPI mode-0 frame of variable length, MSB first.
// Does: shifts out the low len_i bits of tx_i, captures len_i bits right-aligned.
// Assumes: 1 <= len_i <= MAXW, start_i only while idle.
module adc_spi_frame #(
    parameter int MAXW = 30,
    parameter int LENW = 5,
    parameter int HALF = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [LENW-1:0] len_i,
    input  logic [MAXW-1:0] tx_i,
    output logic            done_o,
    output logic [MAXW-1:0] rx_o,
    output logic            sclk_o,
    output logic            cs_n_o,
    output logic            mosi_o,
    input  logic            miso_i
);
    localparam int DW = $clog2(HALF + 1);

    logic            active_q;
    logic [DW-1:0]   div_q;
    logic [LENW-1:0] bits_q;
    logic [LENW-1:0] len_q;
    logic [MAXW-1:0] tx_sh;

    // Purpose: divider, edge generation, shifting and end-of-frame detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            div_q    <= '0;
            bits_q   <= '0;
            len_q    <= '0;
            tx_sh    <= '0;
            rx_o     <= '0;
            sclk_o   <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !active_q) begin
                active_q <= 1'b1;
                div_q    <= '0;
                bits_q   <= '0;
                len_q    <= len_i;
                tx_sh    <= tx_i << (LENW'(MAXW) - len_i);
                rx_o     <= '0;
                sclk_o   <= 1'b0;
            end else if (active_q) begin
                if (div_q == DW'(HALF - 1)) begin
                    div_q <= '0;
                    if (!sclk_o) begin
                        sclk_o <= 1'b1;
                        rx_o   <= {rx_o[MAXW-2:0], miso_i};
                        bits_q <= bits_q + 1'b1;
                    end else begin
                        sclk_o <= 1'b0;
                        if (bits_q == len_q) begin
                            active_q <= 1'b0;
                            done_o   <= 1'b1;
                        end else begin
                            tx_sh <= tx_sh << 1;
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign cs_n_o = !active_q;
    assign mosi_o = active_q && tx_sh[MAXW-1];

    // R9: serial clock rests low outside a frame
    a_r9_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    // R9: MOSI only moves while SCLK is low
    a_r9_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sclk_o) && sclk_o && !cs_n_o) |-> $stable(mosi_o));
endmodule

// File: rtl/adc_spi_ctrl.sv
// Module: top of the multichannel SAR ADC serial conversion controller.
// Does: start-up sequence, host channel reads and full configuration writes,
//       frame length from the cached read-back bit, result extraction.
// Assumes: RES is 14 or 16, NCH is 4 or 8, requests are held until busy rises.
module adc_spi_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int RES       = 16,
    parameter int NCH       = 8,
    parameter int CLK_HZ    = 50_000_000,
    parameter int GAP_NS    = 2000,
    parameter int SCLK_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] req_ch_i,
    input  logic             cfg_wr_i,
    input  logic [15:0]      cfg_wdata_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [RES-1:0]   data_o,
    output logic [CFG_W-1:0] cfg_rdata_o,
    output logic             sclk_o,
    output logic             cs_n_o,
    output logic             mosi_o,
    input  logic             miso_i
);
    localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int MAXW    = RES + CFG_W;
    localparam int LENW    = $clog2(MAXW + 1);
    localparam int GAP_RAW = ((CLK_HZ / 1000) * GAP_NS + 999_999) / 1_000_000;
    localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam int GCW     = $clog2(GAP_CYC + 1);

    function automatic logic [LENW-1:0] frame_len(input logic rb_off);
        return rb_off ? LENW'(RES) : LENW'(MAXW);
    endfunction

    seq_state_t      state_q;
    logic            rd_op_q, rx_phase_q, init_q;
    logic [1:0]      dummies_q;
    logic [LENW-1:0] len_q;
    logic [CFG_W-1:0] cfg;
    logic            frame_done, gap_done;
    logic [MAXW-1:0] rx_word, tx_word;
    logic            take_wr, take_rd, dummy_next, more_frames;
    logic            cache_ch_wr;
    logic [CHW-1:0]  cache_ch;

    // Purpose: decode acceptance and start-up channel updates.
    always_comb begin
        take_wr     = (state_q == SQ_IDLE) && cfg_wr_i;
        take_rd     = (state_q == SQ_IDLE) && !cfg_wr_i && req_i;
        more_frames = rd_op_q && !rx_phase_q;
        dummy_next  = (state_q == SQ_GAP) && gap_done && !more_frames && (dummies_q != 2'd0);
        cache_ch_wr = take_rd || dummy_next;
        cache_ch    = take_rd ? req_ch_i : '0;
        tx_word     = rx_phase_q ? '0 : (MAXW'(cfg) << (len_q - LENW'(CFG_W)));
    end

    adc_cfg_cache #(.CHW(CHW)) u_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .full_wr_i   (take_wr),
        .full_data_i (cfg_wdata_i[CFG_W-1:0]),
        .ch_wr_i     (cache_ch_wr),
        .ch_i        (cache_ch),
        .cfg_o       (cfg)
    );

    adc_spi_frame #(.MAXW(MAXW), .LENW(LENW), .HALF(SCLK_HALF)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (state_q == SQ_LAUNCH),
        .len_i   (len_q),
        .tx_i    (tx_word),
        .done_o  (frame_done),
        .rx_o    (rx_word),
        .sclk_o  (sclk_o),
        .cs_n_o  (cs_n_o),
        .mosi_o  (mosi_o),
        .miso_i  (miso_i)
    );

    adc_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i ((state_q == SQ_XFER) && frame_done),
        .done_o  (gap_done)
    );

    // Purpose: sequence frames and gaps, capture results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_LAUNCH;
            rd_op_q    <= 1'b0;
            rx_phase_q <= 1'b0;
            dummies_q  <= 2'd2;
            init_q     <= 1'b1;
            len_q      <= frame_len(CFG_DEFAULT[0]);
            valid_o    <= 1'b0;
            data_o     <= '0;
        end else begin
            valid_o <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (take_wr || take_rd) begin
                        len_q      <= frame_len(cfg[0]);
                        rd_op_q    <= take_rd;
                        rx_phase_q <= 1'b0;
                        state_q    <= SQ_LAUNCH;
                    end
                end
                SQ_LAUNCH: state_q <= SQ_XFER;
                SQ_XFER: begin
                    if (frame_done) begin
                        if (rx_phase_q) begin
                            data_o  <= cfg[0] ? rx_word[RES-1:0] : rx_word[CFG_W +: RES];
                            valid_o <= !init_q;
                        end
                        state_q <= SQ_GAP;
                    end
                end
                SQ_GAP: begin
                    if (gap_done) begin
                        if (more_frames) begin
                            rx_phase_q <= 1'b1;
                            state_q    <= SQ_LAUNCH;
                        end else if (dummies_q != 2'd0) begin
                            dummies_q  <= dummies_q - 1'b1;
                            rd_op_q    <= 1'b1;
                            rx_phase_q <= 1'b0;
                            state_q    <= SQ_LAUNCH;
                        end else begin
                            init_q  <= 1'b0;
                            state_q <= SQ_IDLE;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != SQ_IDLE);
    assign cfg_rdata_o = cfg;

    // Checker state: cycles chip select has been high, and whether a frame has ended.
    logic [GCW-1:0] hi_cnt_q;
    logic           seen_q;

    // Purpose: measure the chip-select high run for the gap assertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
            seen_q   <= 1'b0;
        end else begin
            if (!cs_n_o)                        hi_cnt_q <= '0;
            else if (hi_cnt_q != GCW'(GAP_CYC)) hi_cnt_q <= hi_cnt_q + 1'b1;
            if (frame_done) seen_q <= 1'b1;
        end
    end

    // R7: a new frame never starts before the gap has elapsed
    a_r7_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $fell(cs_n_o)) |-> (hi_cnt_q >= GCW'(GAP_CYC)));
    // R8: the valid strobe lasts one cycle
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R8: results are only presented while the sequence is still busy
    a_r8_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> busy_o);
    // R2: an accepted full write lands masked to 14 bits
    a_r2_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cfg_wr_i) |=> (cfg_rdata_o == $past(cfg_wdata_i[CFG_W-1:0])));
    // R8: nothing is accepted while busy, so the cache holds still outside gaps
    a_r8_cache_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(state_q == SQ_GAP)) |=> $stable(cfg_rdata_o));
endmodule

// File: tb/tb_adc_spi_ctrl.sv
module tb_adc_spi_ctrl;
    localparam int RES = 16;
    localparam int CHW = 3;
    localparam int GAP_MIN = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [CHW-1:0] req_ch_i = '0;
    logic        cfg_wr_i = 1'b0;
    logic [15:0] cfg_wdata_i = '0;
    logic        busy_o, valid_o, sclk_o, cs_n_o, mosi_o;
    logic        miso_i = 1'b0;
    logic [RES-1:0] data_o;
    logic [13:0] cfg_rdata_o;

    always #10 clk = ~clk;

    adc_spi_ctrl #(.RES(RES), .NCH(8), .CLK_HZ(50_000_000), .GAP_NS(2000), .SCLK_HALF(2)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_ch_i(req_ch_i),
        .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .busy_o(busy_o),
        .valid_o(valid_o), .data_o(data_o), .cfg_rdata_o(cfg_rdata_o),
        .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Converter model: mode 0 slave, logs each frame's MOSI bits and bit count.
    logic [31:0] resp = '0;
    int          resp_len = 16;
    logic [31:0] cap, sh;
    int          nb;
    logic        in_frame = 1'b0;
    logic [31:0] fr_word [0:15];
    int          fr_bits [0:15];
    int          fr_n = 0;

    always @(negedge cs_n_o) begin
        in_frame = 1'b1;
        cap = '0;
        nb = 0;
        sh = resp << (32 - resp_len);
        miso_i = sh[31];
    end
    always @(posedge sclk_o) if (in_frame) begin
        cap = {cap[30:0], mosi_o};
        nb++;
    end
    always @(negedge sclk_o) if (in_frame) begin
        sh = sh << 1;
        miso_i = sh[31];
    end
    always @(posedge cs_n_o) if (in_frame) begin
        in_frame = 1'b0;
        if (fr_n < 16) begin
            fr_word[fr_n] = cap;
            fr_bits[fr_n] = nb;
        end
        fr_n++;
    end

    // Valid counting and gap measurement at the falling clock edge.
    int          vcnt = 0;
    logic [RES-1:0] vdata = '0;
    int          hi_run = 0;
    int          gap_min = 1000000;
    always @(negedge clk) begin
        if (valid_o) begin
            vcnt++;
            vdata = data_o;
        end
        if (rst_n && fr_n > 0) begin
            if (cs_n_o) hi_run++;
            else if (hi_run > 0) begin
                if (hi_run < gap_min) gap_min = hi_run;
                hi_run = 0;
            end
        end else hi_run = 0;
    end

    task automatic wait_busy(input logic lvl);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (busy_o === lvl) return;
        end
        chk("R8 busy timeout", {31'b0, busy_o}, {31'b0, lvl});
    endtask

    task automatic do_read(input logic [CHW-1:0] ch, input logic [31:0] r, input int rl);
        resp = r;
        resp_len = rl;
        fr_n = 0;
        @(negedge clk);
        req_i = 1'b1;
        req_ch_i = ch;
        wait_busy(1'b1);
        req_i = 1'b0;
        wait_busy(1'b0);
    endtask

    task automatic do_write(input logic [15:0] w);
        fr_n = 0;
        @(negedge clk);
        cfg_wr_i = 1'b1;
        cfg_wdata_i = w;
        wait_busy(1'b1);
        cfg_wr_i = 1'b0;
        wait_busy(1'b0);
    endtask

    // Stimulus table: {channel, 16-bit code returned by the converter}.
    localparam logic [18:0] VEC [0:5] = '{
        {3'd0, 16'h1234}, {3'd1, 16'hFFFF}, {3'd2, 16'h0000},
        {3'd3, 16'h8001}, {3'd6, 16'h5A5A}, {3'd7, 16'h7FFE}
    };

    logic [13:0] exp_cfg;
    int          v0;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        chk("R1 busy in reset", {31'b0, busy_o}, 32'd1);
        chk("R1 default cfg", {18'b0, cfg_rdata_o}, 32'h3C79);
        chk("R9 sclk idle low", {31'b0, sclk_o}, 32'd0);
        fr_n = 0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", {31'b0, busy_o}, 32'd1);
        wait_busy(1'b0);
        chk("R1 start-up frame count", fr_n, 5);
        chk("R1 default cfg frame", fr_word[0], 32'h3C79 << 2);
        chk("R1 default frame length", fr_bits[0], RES);
        chk("R3 dummy read channel 0", fr_word[1], 32'h3C79 << 2);
        chk("R4 dummy rx frame zero", fr_word[2], 32'h0);
        chk("R3 second dummy channel 0", fr_word[3], 32'h3C79 << 2);
        chk("R4 second dummy rx zero", fr_word[4], 32'h0);
        chk("R1 no valid during start-up", vcnt, 0);

        exp_cfg = 14'h3C79;
        for (int i = 0; i < 6; i++) begin
            v0 = vcnt;
            exp_cfg[9:7] = VEC[i][18:16];
            do_read(VEC[i][18:16], {16'b0, VEC[i][15:0]}, RES);
            chk("R3 cfg frame merges channel", fr_word[0], {18'b0, exp_cfg} << 2);
            chk("R3 cache holds channel", {18'b0, cfg_rdata_o}, {18'b0, exp_cfg});
            chk("R4 rx frame MOSI zero", fr_word[1], 32'h0);
            chk("R5 frame length", fr_bits[1], RES);
            chk("R5 code", {16'b0, vdata}, {16'b0, VEC[i][15:0]});
            chk("R8 one valid per read", vcnt - v0, 1);
        end
        chk("R7 minimum gap", {31'b0, gap_min >= GAP_MIN}, 32'd1);

        // Enable read-back: length still from previous (disabled) state.
        do_write(16'hFC78);
        chk("R2 masked write", {18'b0, cfg_rdata_o}, 32'h3C78);
        chk("R2 write frame length old state", fr_bits[0], RES);
        chk("R2 write left aligned", fr_word[0], 32'h3C78 << 2);

        do_read(3'd5, (32'hBEEF << 14) | 32'h1234, RES + 14);
        chk("R6 long cfg frame length", fr_bits[0], RES + 14);
        chk("R6 cfg frame left aligned", fr_word[0], 32'h3EF8 << 16);
        chk("R6 long rx frame length", fr_bits[1], RES + 14);
        chk("R4 long rx frame zero", fr_word[1], 32'h0);
        chk("R6 shifted code", {16'b0, vdata}, 32'hBEEF);

        do_write(16'h3C79);
        chk("R2 disable write uses long frame", fr_bits[0], RES + 14);
        chk("R2 disable write aligned", fr_word[0], 32'h3C79 << 16);

        // Hold-off: write presented during a read waits for it.
        resp = 32'hA5A5;
        resp_len = RES;
        fr_n = 0;
        @(negedge clk);
        req_i = 1'b1;
        req_ch_i = 3'd7;
        wait_busy(1'b1);
        req_i = 1'b0;
        repeat (20) @(negedge clk);
        cfg_wr_i = 1'b1;
        cfg_wdata_i = 16'h0A5B;
        for (int i = 0; i < 5000 && !valid_o; i++) @(negedge clk);
        chk("R8 write held during read", {18'b0, cfg_rdata_o}, 32'h3FF9);
        for (int i = 0; i < 5000 && cfg_rdata_o != 14'h0A5B; i++) @(negedge clk);
        cfg_wr_i = 1'b0;
        wait_busy(1'b0);
        chk("R8 deferred write applied", {18'b0, cfg_rdata_o}, 32'h0A5B);
        chk("R8 frames read then write", fr_n, 3);
        chk("R9 deferred write frame", fr_word[2], 32'h0A5B << 2);
        chk("R5 held read code", {16'b0, vdata}, 32'hA5A5);

        // Reset in the middle of a read restarts the start-up sequence.
        @(negedge clk);
        req_i = 1'b1;
        req_ch_i = 3'd4;
        wait_busy(1'b1);
        req_i = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset restores default", {18'b0, cfg_rdata_o}, 32'h3C79);
        fr_n = 0;
        v0 = vcnt;
        rst_n = 1'b1;
        @(negedge clk);
        wait_busy(1'b0);
        chk("R1 start-up repeated", fr_n, 5);
        chk("R1 no valid after reset", vcnt - v0, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule